// File: doc/BRIEF.md
# Programmable System Clock Divider Bank

This block derives several clock-enable strobes from a single source clock, each through a divider that software programs. There are five dividers. One is a prescaler that runs from the source clock. Three are system dividers that count either every source cycle or every prescaler strobe, depending on a bypass select from the clock control logic. The last is an output divider that always runs from the source clock. Each output is a registered strobe that is high for one source cycle per divided period, so downstream logic uses it as a clock enable.

Each divider has a 16-bit control word on a small register bus. The word holds an enable flag and a 5-bit ratio code. Only the system dividers restrict which codes are legal: a write carrying a reserved code is dropped as a whole. A change of ratio is held back until the running period completes, so no output period is ever cut short.

Top module: `clkdiv_bank`

## Requirements
- R1: Register addresses are 0 for the prescaler, 1 to 3 for system dividers 1 to 3, and 4 for the output divider. Each word has the enable flag at bit 15 and the ratio code at bits 4:0. `reg_rdata` shows the word at `reg_addr` one clock later. Other addresses read 0, and writes to them are ignored.
- R2: After reset the words read 0x8000 for the prescaler, 0x8003 for each system divider and 0x0000 for the output divider.
- R3: Bits 14:5 of every word read back as 0, whatever was written to them.
- R4: On the prescaler and the output divider, ratio code N gives a strobe one cycle wide every N+1 source cycles. Code 0 keeps the strobe high.
- R5: On a system divider, codes 0, 1 and 3 divide its tick source by 1, 2 and 4.
- R6: A write of a system-divider word whose ratio code is 2 or 4..31 is ignored entirely. The enable flag and the ratio code keep their previous values.
- R7: With `pll_sel`=0 the system dividers count every source cycle. With `pll_sel`=1 they count prescaler strobes, so the period is (P+1)*D for prescaler code P and divide ratio D.
- R8: A divider whose enable flag is 0 drives its output low from the next cycle and holds its counter cleared.
- R9: A new ratio takes effect only at the end of the running period. The period in progress completes at its old length.
- R10: The output divider counts source cycles regardless of `pll_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_sel | input | 1 | Tick source for the system dividers: 1 selects prescaler strobes, 0 selects every source cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, used for both write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| div_out | output | 5 | Strobes: bit 0 prescaler, bits 1-3 system dividers, bit 4 output divider |

## Verification
The bench measures the spacing between strobes rather than sampling single cycles, so it checks the period itself.

- **Cascade through the bypass select:** it sweeps ratio codes through the prescaler and the system dividers with both settings of `pll_sel`. A design that multiplied the ratios wrongly, or ignored the select, shows the wrong spacing.
- **Reserved system code:** it writes a reserved code to a system divider. A design that stored the code would read back a changed word.
- **Reserved bits:** it writes ones into the reserved bits. A design that stored them would return them on a read.
- **Ratio change mid-period:** it shrinks the output divider's ratio from 32 to 1 in the middle of a period. A design that loaded the new ratio at once would show a gap shorter than 32 cycles.
- **Disabled divider:** it checks that a disabled divider stays low, which catches a counter left free-running.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int RATIO_W = 5;
  localparam int IDX_PRE = 0;

  // Legal system-divider codes: 0 (div 1), 1 (div 2), 3 (div 4)
  function automatic logic sys_code_ok(input logic [RATIO_W-1:0] code);
    return (code == 5'd0) || (code == 5'd1) || (code == 5'd3);
  endfunction
endpackage

// File: rtl/clkdiv_regfile.sv
module clkdiv_regfile
  import clkdiv_pkg::*;
#(
  parameter int NUM_SYS = 3,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int EN_BIT  = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_SYS+1:0]         en_o,
  output logic [(NUM_SYS+2)*RATIO_W-1:0] ratio_o
);
  localparam int NUM_DIV = NUM_SYS + 2;
  localparam int IDX_OSC = NUM_SYS + 1;

  logic [NUM_DIV-1:0] en_q;
  logic [RATIO_W-1:0] ratio_q [NUM_DIV];
  logic [RATIO_W-1:0] wcode;

  assign wcode = wdata[RATIO_W-1:0];

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_reg
    localparam bit IS_SYS = (i != IDX_PRE) && (i != IDX_OSC);
    localparam logic RST_EN = (i != IDX_OSC);
    localparam logic [RATIO_W-1:0] RST_RATIO = IS_SYS ? 5'd3 : 5'd0;
    logic hit;
    assign hit = we && (addr == ADDR_W'(i)) && (!IS_SYS || sys_code_ok(wcode));
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]    <= RST_EN;
        ratio_q[i] <= RST_RATIO;
      end else if (hit) begin
        en_q[i]    <= wdata[EN_BIT];
        ratio_q[i] <= wcode;
      end
    end
    assign ratio_o[i*RATIO_W +: RATIO_W] = ratio_q[i];
  end

  assign en_o = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      for (int k = 0; k < NUM_DIV; k++) begin
        if (addr == ADDR_W'(k)) begin
          rdata[EN_BIT]        <= en_q[k];
          rdata[RATIO_W-1:0]   <= ratio_q[k];
        end
      end
    end
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               tick,
  output logic               strobe
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] limit;
  logic               run;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      limit  <= '0;
      run    <= 1'b0;
      strobe <= 1'b0;
    end else if (!run) begin
      limit  <= ratio;
      run    <= 1'b1;
      strobe <= 1'b0;
    end else if (tick) begin
      if (cnt == limit) begin
        cnt    <= '0;
        limit  <= ratio;
        strobe <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        strobe <= 1'b0;
      end
    end else begin
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_SYS = 3,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int EN_BIT  = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pll_sel,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_SYS+1:0]   div_out
);
  localparam int NUM_DIV = NUM_SYS + 2;
  localparam int IDX_OSC = NUM_SYS + 1;

  logic [NUM_DIV-1:0]         div_en;
  logic [NUM_DIV*RATIO_W-1:0] div_ratio;
  logic [NUM_DIV-1:0]         tick;

  clkdiv_regfile #(
    .NUM_SYS(NUM_SYS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_o(div_en), .ratio_o(div_ratio)
  );

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    if (i == IDX_PRE || i == IDX_OSC) begin : g_src
      assign tick[i] = 1'b1;
    end else begin : g_mux
      assign tick[i] = pll_sel ? div_out[IDX_PRE] : 1'b1;
    end
    clkdiv_counter u_cnt (
      .clk(clk), .rst(rst), .en(div_en[i]),
      .ratio(div_ratio[i*RATIO_W +: RATIO_W]),
      .tick(tick[i]), .strobe(div_out[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_SYS = 3,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           reg_we,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [DATA_W-1:0]              reg_wdata,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic [NUM_SYS+1:0]             div_en,
  input logic [(NUM_SYS+2)*RATIO_W-1:0] div_ratio,
  input logic [NUM_SYS+1:0]             div_out
);
  localparam int NUM_DIV = NUM_SYS + 2;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[14:5] == '0); // R3

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_off
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
      !div_en[i] |=> !div_out[i]); // R8
  end

  for (genvar i = 1; i <= NUM_SYS; i++) begin : g_sys
    AST_SYS_LEGAL: assert property (@(posedge clk) disable iff (rst)
      sys_code_ok(div_ratio[i*RATIO_W +: RATIO_W])); // R5
    AST_BAD_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
      (reg_we && reg_addr == ADDR_W'(i) && !sys_code_ok(reg_wdata[RATIO_W-1:0]))
      |=> ($stable(div_ratio[i*RATIO_W +: RATIO_W]) && $stable(div_en[i]))); // R6
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .NUM_SYS(NUM_SYS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_en(div_en),
  .div_ratio(div_ratio), .div_out(div_out)
);

// File: tb/sim_clkdiv_bank.sv
`timescale 1ns/1ps
module sim_clkdiv_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pll_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [4:0]  div_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkdiv_bank u0 (
    .clk(clk), .rst(rst), .pll_sel(pll_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_out(div_out)
  );

  // row: {prescaler code[4:0], divider index[2:0], code[4:0], pll_sel}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {5'd0,  3'd0, 5'd5,  1'b0},
    {5'd31, 3'd0, 5'd31, 1'b0},
    {5'd0,  3'd1, 5'd0,  1'b0},
    {5'd0,  3'd2, 5'd1,  1'b0},
    {5'd0,  3'd3, 5'd3,  1'b0},
    {5'd2,  3'd1, 5'd1,  1'b1},
    {5'd4,  3'd3, 5'd3,  1'b1},
    {5'd7,  3'd2, 5'd0,  1'b1},
    {5'd0,  3'd4, 5'd9,  1'b1},
    {5'd5,  3'd4, 5'd0,  1'b0},
    {5'd31, 3'd1, 5'd3,  1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic period(input int idx, output int p);
    int t;
    t = 0;
    @(negedge clk);
    while (!div_out[idx] && t < 2000) begin @(negedge clk); t++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!div_out[idx] && p < 2000);
  endtask

  function automatic int expect_period(input int pre, input int idx, input int code, input bit sel);
    if (idx == 0 || idx == 4) return code + 1;
    return (sel ? pre + 1 : 1) * (code + 1);
  endfunction

  initial begin
    logic [15:0] d;
    int p;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset values, R1 unmapped address
    rd(3'd0, d); check("R2 pre reset", d, 16'h8000);
    rd(3'd1, d); check("R2 sys1 reset", d, 16'h8003);
    rd(3'd3, d); check("R2 sys3 reset", d, 16'h8003);
    rd(3'd4, d); check("R2 osc reset", d, 16'h0000);
    rd(3'd6, d); check("R1 unmapped read", d, 0);
    check("R8 osc off after reset", div_out[4], 0);
    period(1, p); check("R5 sys1 reset div4", p, 4);

    // table walk: R4 R5 R7 R10
    for (int i = 0; i < NV; i++) begin
      int pre, idx, code; bit sel;
      pre = VEC[i][13:9]; idx = VEC[i][8:6]; code = VEC[i][5:1]; sel = VEC[i][0];
      wr(3'd0, 16'h8000 | 16'(pre));
      wr(3'(idx), 16'h8000 | 16'(code));
      pll_sel = sel;
      repeat (300) @(negedge clk);
      period(idx, p);
      check("R4 R5 R7 R10 period", p, expect_period(pre, idx, code, sel));
    end

    // R6 reserved system code ignored
    wr(3'd2, 16'h8003);
    wr(3'd2, 16'h0002);
    rd(3'd2, d); check("R6 code 2 dropped", d, 16'h8003);
    wr(3'd2, 16'h0007);
    rd(3'd2, d); check("R6 code 7 dropped", d, 16'h8003);

    // R3 reserved bits, R8 disabled prescaler low
    wr(3'd0, 16'h7FE2);
    rd(3'd0, d); check("R3 reserved bits zero", d, 16'h0002);
    repeat (5) @(negedge clk);
    p = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); p += div_out[0]; end
    check("R8 disabled prescaler low", p, 0);

    // R1 write to unmapped address ignored
    wr(3'd7, 16'h8001);
    rd(3'd7, d); check("R1 unmapped write", d, 0);
    rd(3'd4, d); check("R1 osc untouched", d, 16'h8000);

    // R9 ratio change mid-period keeps old length
    wr(3'd4, 16'h801F);
    repeat (80) @(negedge clk);
    @(negedge clk);
    while (!div_out[4]) @(negedge clk);
    p = 0;
    do begin
      @(negedge clk); p++;
      if (p == 3) begin reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h8000; end
      if (p == 4) reg_we = 1'b0;
    end while (!div_out[4] && p < 200);
    check("R9 old period completes", p, 32);
    period(4, p); check("R9 new ratio after boundary", p, 1);

    // R8 disable output divider
    wr(3'd4, 16'h0000);
    @(negedge clk);
    check("R8 osc disabled low", div_out[4], 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule